// File: doc/BRIEF.md
# Parallel EEPROM Byte Write and Completion Poll Controller

This controller sits on the host side of a 512-byte parallel EEPROM with an 8-bit bidirectional data bus. A request carries a 9-bit address, an 8-bit data byte and an operation select, and is accepted over a valid/ready handshake. For a write, the controller drives the address and data and pulses the active-low write strobe while chip select is low and output enable is high. It then reads the same address again and again. Each read returns either the complement of the written top bit, which means the device is still programming, or the true top bit, which means the write has finished. The controller reports done when the true bit appears. It reports an error if the device is still busy after a fixed number of reads.

A read request performs one read window and returns the sampled byte. Every strobe leaves a flip-flop. The data bus is split into an output value, an output-enable and an input value, so a tristate buffer can be placed at the pad. Between operations chip select is held high, which keeps the device in standby. All phase lengths are parameters counted in clocks. The write pulse default of 3 clocks is wider than the device's 10 ns glitch filter at any clock up to 100 MHz.

Top module: `eeprom_wpoll`

## Requirements
- R1: While reset is high and in the first cycle after it, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `req_ready` is 1, and `done` and `error` are 0.
- R2: A write (`req_write`=1) accepted on a rising edge with `req_valid` and `req_ready` both high gives SETUP_CLKS cycles with `mem_ce_n`=0, `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=1. These are followed by WE_PULSE_CLKS cycles with `mem_we_n`=0 while chip select, output enable and bus drive stay unchanged.
- R3: From the cycle after acceptance until the next acceptance, `mem_addr` equals the accepted address and `mem_dq_out` equals the accepted data. After the write strobe rises, the bus is still driven for one more cycle.
- R4: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. Every read window is preceded by one cycle with `mem_ce_n`=0, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R5: A read window lasts OE_DELAY_CLKS cycles with `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1. `mem_dq_in` is sampled only on the edge that ends the window.
- R6: During a write poll, if bit 7 of the sampled byte differs from bit 7 of the written data, another turnaround cycle and read window follow. If it matches, the next cycle is the done cycle.
- R7: If MAX_POLLS consecutive poll reads all show the complement, `error` is 1 for one cycle and `done` stays 0. `done` and `error` are never 1 together.
- R8: `done` or `error` is high for exactly one cycle. In that cycle `req_ready` is 0 and `mem_ce_n` is 1. `req_ready` returns to 1 in the next cycle.
- R9: While an operation is in progress, `req_ready` is 0 and `req_valid` is ignored. A new address or data offered during an operation does not change `mem_addr` or `mem_dq_out`.
- R10: A read (`req_write`=0) performs one turnaround cycle and one read window. `rd_data` holds the sampled byte during the done cycle.
- R11: When no operation is in progress, `mem_ce_n` is 1 and `mem_dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = byte write with polling, 0 = single read |
| req_addr | input | 9 | Byte address |
| req_wdata | input | 8 | Byte to write |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle poll timeout pulse |
| rd_data | output | 8 | Last sampled byte |
| mem_addr | output | 9 | Address to the device |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | 1 = host drives the data bus |
| mem_dq_in | input | 8 | Value read from the data bus |

## Verification
The strobes of the first phase appear in the cycle after the accepting edge. A write reaches its first read window SETUP_CLKS + WE_PULSE_CLKS + 2 cycles after acceptance. Each read window is sampled OE_DELAY_CLKS cycles after it opens, and the done or error cycle follows that sampling edge directly. The bench holds a queue of expected pin states for every coming cycle and pops one entry at each falling edge. When a sampling entry is popped, it decides the continuation from the byte its own device model presents at that moment. A busy result appends another turnaround cycle and read window, a true result or a read appends the done cycle, and the limit appends the error cycle.

// File: rtl/epc_pkg.sv
package epc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_TURN,
    ST_READ,
    ST_DONE,
    ST_FAIL
  } epc_state_t;
endpackage

// File: rtl/epc_phase_timer.sv
module epc_phase_timer #(
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          last
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - TW'(1);
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/epc_poll_counter.sv
module epc_poll_counter #(
  parameter int MAX_POLLS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic bump,
  output logic exhausted
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (bump)    cnt <= cnt + CW'(1);
  end

  assign exhausted = (cnt == CW'(MAX_POLLS - 1));

  // R7
  poll_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(MAX_POLLS));
endmodule

// File: rtl/eeprom_wpoll.sv
module eeprom_wpoll
  import epc_pkg::*;
#(
  parameter int ADDR_W        = 9,
  parameter int DATA_W        = 8,
  parameter int SETUP_CLKS    = 1,
  parameter int WE_PULSE_CLKS = 3,
  parameter int OE_DELAY_CLKS = 3,
  parameter int MAX_POLLS     = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic              error,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int PH_A   = (SETUP_CLKS > WE_PULSE_CLKS) ? SETUP_CLKS : WE_PULSE_CLKS;
  localparam int PH_MAX = (PH_A > OE_DELAY_CLKS) ? PH_A : OE_DELAY_CLKS;
  localparam int TW     = $clog2(PH_MAX + 1);
  localparam int MSB    = DATA_W - 1;

  epc_state_t    state, nxt;
  logic          op_wr;
  logic          t_load, t_last;
  logic [TW-1:0] t_val;
  logic          accept, sample, poll_clr, poll_bump, poll_out;

  epc_phase_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .last(t_last)
  );

  epc_poll_counter #(.MAX_POLLS(MAX_POLLS)) u_polls (
    .clk(clk), .rst(rst), .clear(poll_clr), .bump(poll_bump), .exhausted(poll_out)
  );

  always_comb begin
    nxt       = state;
    t_load    = 1'b0;
    t_val     = '0;
    accept    = 1'b0;
    sample    = 1'b0;
    poll_bump = 1'b0;
    case (state)
      ST_IDLE: if (req_valid) begin
        accept = 1'b1;
        t_load = 1'b1;
        if (req_write) begin
          nxt   = ST_WSETUP;
          t_val = TW'(SETUP_CLKS - 1);
        end else begin
          nxt   = ST_TURN;
        end
      end
      ST_WSETUP: if (t_last) begin
        nxt    = ST_WPULSE;
        t_load = 1'b1;
        t_val  = TW'(WE_PULSE_CLKS - 1);
      end
      ST_WPULSE: if (t_last) begin
        nxt    = ST_WHOLD;
        t_load = 1'b1;
      end
      ST_WHOLD: begin
        nxt    = ST_TURN;
        t_load = 1'b1;
      end
      ST_TURN: begin
        nxt    = ST_READ;
        t_load = 1'b1;
        t_val  = TW'(OE_DELAY_CLKS - 1);
      end
      ST_READ: if (t_last) begin
        sample = 1'b1;
        if (!op_wr || (mem_dq_in[MSB] == mem_dq_out[MSB])) begin
          nxt = ST_DONE;
        end else if (poll_out) begin
          nxt = ST_FAIL;
        end else begin
          poll_bump = 1'b1;
          nxt       = ST_TURN;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign poll_clr = accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_ready <= 1'b1;
      done      <= 1'b0;
      error     <= 1'b0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      state     <= nxt;
      req_ready <= (nxt == ST_IDLE);
      done      <= (nxt == ST_DONE);
      error     <= (nxt == ST_FAIL);
      mem_ce_n  <= (nxt == ST_IDLE) || (nxt == ST_DONE) || (nxt == ST_FAIL);
      mem_oe_n  <= (nxt != ST_READ);
      mem_we_n  <= (nxt != ST_WPULSE);
      mem_dq_oe <= (nxt == ST_WSETUP) || (nxt == ST_WPULSE) || (nxt == ST_WHOLD);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_wr      <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rd_data    <= '0;
    end else begin
      if (accept) begin
        op_wr      <= req_write;
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (sample) rd_data <= mem_dq_in;
    end
  end

  // R4
  no_bus_fight_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe);
  // R4
  turnaround_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));
  // R2
  we_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));
  // R3
  we_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_out) && $stable(mem_addr)));
  // R8
  result_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (done || error) |=> (req_ready && !done && !error));
  // R8
  result_standby_chk: assert property (@(posedge clk) disable iff (rst)
    (done || error) |-> (mem_ce_n && !req_ready));
  // R7
  result_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && error));
  // R11
  idle_standby_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && !mem_dq_oe));
endmodule

// File: tb/eeprom_wpoll_test.sv
module eeprom_wpoll_test;
  localparam int AW = 9, DW = 8, SU = 2, WP = 2, OD = 3, MP = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, done, error, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] rd_data, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;

  eeprom_wpoll #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CLKS(SU), .WE_PULSE_CLKS(WP),
                 .OE_DELAY_CLKS(OD), .MAX_POLLS(MP)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .error(error), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // Behavioural device: commits on the write strobe's rising edge, then answers
  // reads of that address with the complemented top bit while busy.
  logic [DW-1:0] mem [512];
  logic [AW-1:0] last_a;
  logic [DW-1:0] last_d;
  int            busy_cnt;
  logic          prev_we;
  bit            stuck = 0;
  int            busy_len = 10;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 512; i++) mem[i] <= 8'hFF;
      prev_we  <= 1'b1;
      busy_cnt <= 0;
      last_a   <= '0;
      last_d   <= '0;
    end else begin
      prev_we <= mem_we_n;
      if (!prev_we && mem_we_n && !mem_ce_n) begin
        mem[mem_addr] <= mem_dq_out;
        last_a        <= mem_addr;
        last_d        <= mem_dq_out;
        busy_cnt      <= busy_len;
      end else if (busy_cnt > 0) begin
        busy_cnt <= busy_cnt - 1;
      end
    end
  end

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n)
                   ? (((busy_cnt != 0 || stuck) && mem_addr == last_a)
                      ? {~last_d[7], 7'h2A} : mem[mem_addr])
                   : 8'hA5;

  // Reference model: queue of expected pin states, one entry per cycle
  typedef struct packed {
    logic ce_n, oe_n, we_n, dq_oe, ready, done, error, smp;
    logic [3:0] tg;
  } exp_t;

  exp_t eq[$];
  int   n_chk = 0, n_fail = 0, cyc = 0, polls = 0;
  bit   cur_wr = 0;
  logic [AW-1:0] cur_addr = '0;
  logic [DW-1:0] cur_data = '0, exp_rd = '0;

  function automatic string tg(input int c);
    case (c)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic void push(input bit ce, oe, we, dq, rdy, dn, er, smp_last,
                               input int tag, input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e = '{ce, oe, we, dq, rdy, dn, er, (smp_last && i == n - 1), 4'(tag)};
      eq.push_back(e);
    end
  endfunction

  function automatic void push_poll(input int tag);
    push(0, 1, 1, 0, 0, 0, 0, 0, 4, 1);
    push(0, 0, 1, 0, 0, 0, 0, 1, tag, OD);
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      exp_t e;
      bit   idle_e;
      logic [DW-1:0] v;
      cyc++;
      idle_e = (eq.size() == 0);
      if (idle_e) e = '{1, 1, 1, 0, 1, 0, 0, 0, 4'd11};
      else        e = eq.pop_front();
      chk(mem_ce_n  == e.ce_n,  tg(e.tg), mem_ce_n,  e.ce_n);
      chk(mem_oe_n  == e.oe_n,  tg(e.tg), mem_oe_n,  e.oe_n);
      chk(mem_we_n  == e.we_n,  tg(e.tg), mem_we_n,  e.we_n);
      chk(mem_dq_oe == e.dq_oe, tg(e.tg), mem_dq_oe, e.dq_oe);
      chk(req_ready == e.ready, tg(e.tg), req_ready, e.ready);
      chk(done      == e.done,  e.done  ? "R8" : tg(e.tg), done,  e.done);
      chk(error     == e.error, e.error ? "R7" : tg(e.tg), error, e.error);
      chk(!(!mem_oe_n && mem_dq_oe), "R4", mem_dq_oe, 0);
      if (!mem_ce_n)  chk(mem_addr == cur_addr, "R3", mem_addr, cur_addr);
      if (mem_dq_oe)  chk(mem_dq_out == cur_data, "R3", mem_dq_out, cur_data);
      if (!e.ready && req_valid) chk(req_ready == 1'b0, "R9", req_ready, 0);
      if (e.done && !cur_wr) chk(rd_data == exp_rd, "R10", rd_data, exp_rd);
      if (e.smp) begin
        v = mem_dq_in;
        if (!cur_wr) begin
          exp_rd = v;
          push(1, 1, 1, 0, 0, 1, 0, 0, 10, 1);
        end else if (v[7] == cur_data[7]) begin
          push(1, 1, 1, 0, 0, 1, 0, 0, 6, 1);
        end else begin
          polls++;
          if (polls >= MP) push(1, 1, 1, 0, 0, 0, 1, 0, 7, 1);
          else             push_poll(6);
        end
      end
      if (idle_e && req_valid) begin
        cur_wr = req_write; cur_addr = req_addr; cur_data = req_wdata; polls = 0;
        if (req_write) begin
          push(0, 1, 1, 1, 0, 0, 0, 0, 2, SU);
          push(0, 1, 0, 1, 0, 0, 0, 0, 2, WP);
          push(0, 1, 1, 1, 0, 0, 0, 0, 3, 1);
          push_poll(5);
        end else begin
          push_poll(10);
        end
      end
      if (cyc > 20000) begin
        n_fail++;
        $display("FAIL watchdog R8: actual %0d cycles expected below 20000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input int extra);
    @(posedge clk); #2;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2;
    if (extra > 0) begin
      req_addr = ~a; req_wdata = ~d;   // R9: offered during the operation
      repeat (extra) @(posedge clk);
      #2;
    end
    req_valid = 1'b0;
  endtask

  task automatic wait_result();
    do @(negedge clk); while (!(done || error));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_ce_n == 1'b1, "R1", mem_ce_n, 1);
    chk(mem_oe_n == 1'b1, "R1", mem_oe_n, 1);
    chk(mem_we_n == 1'b1, "R1", mem_we_n, 1);
    chk(mem_dq_oe == 1'b0, "R1", mem_dq_oe, 0);
    chk(req_ready == 1'b1, "R1", req_ready, 1);
    chk(!done && !error, "R1", {done, error}, 0);
    @(posedge clk); #2 rst = 1'b0;
    repeat (2) @(negedge clk);

    busy_len = 10; issue(1, 9'h005, 8'h3C, 0); wait_result();   // R6 several polls
    busy_len = 1;  issue(1, 9'h1FF, 8'hC3, 0); wait_result();   // R2 top bit set
    issue(0, 9'h005, 8'h00, 0); wait_result();                  // R10
    issue(0, 9'h1FF, 8'h00, 0); wait_result();                  // R10
    issue(0, 9'h0A0, 8'h00, 0); wait_result();                  // R10 unwritten byte
    busy_len = 14; issue(1, 9'h0A0, 8'h81, 4); wait_result();   // R9
    issue(0, 9'h0A0, 8'h00, 0); wait_result();
    chk(rd_data == 8'h81, "R9", rd_data, 8'h81);
    stuck = 1; issue(1, 9'h033, 8'h55, 0); wait_result();       // R7 timeout
    stuck = 0; issue(0, 9'h033, 8'h00, 0); wait_result();
    chk(rd_data == 8'h55, "R10", rd_data, 8'h55);
    issue(1, 9'h100, 8'h00, 0); issue(0, 9'h100, 8'h00, 0); wait_result();  // R11 back to back
    chk(rd_data == 8'h00, "R10", rd_data, 8'h00);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule